// File: doc/BRIEF.md
# SDRAM Mode-Register Write Sequencer

This block sits inside a memory bus controller and turns one CPU store into the SDRAM initialization handshake. The CPU writes a byte into one of two reserved 4 KiB address windows, one for each SDRAM chip-select area. The low twelve bits of the store address are the mode value. The block replies with a precharge-all command, then a configurable gap of deselect cycles, then a mode-register-set command. During the mode-register-set command the SDRAM address lines carry the mode value. The data of the store plays no part, so the block has no data input.

The SDRAM address lines are numbered from the device's point of view. With a 32-bit external bus, device line 0 is wired to byte-address bit 2, so the offset is shifted right by two. With a 16-bit bus it is shifted right by one. Both shifts put the write-burst-mode, CAS-latency, wrap and burst-length fields on the same device lines.

The CPU sees a ready signal. The ready signal drops for the length of the sequence. A window store of the wrong size raises a sticky error flag instead of issuing commands. Bus width, the precharge gap and a configuration-valid flag come from static register inputs.

Top module: `sdram_mode_seq`

## Requirements
- R1: After reset, both chip selects, RAS, CAS and WE are high, the address lines are zero, `cpu_rdy` is 1 and `err_size` is 0.
- R2: A store is accepted when all of the following hold in the same cycle: `cpu_wr` and `cpu_rdy` are high, `cfg_valid` is 1, and `cpu_size` is 0 (size encoding: 0 byte, 1 halfword, 2 word). Address 0xFFFFD000+X selects area 2 (`sd_cs2_n`) and address 0xFFFFE000+X selects area 3 (`sd_cs3_n`). Only the chip select of the selected area goes low during the two commands; the other stays high.
- R3: In the cycle after acceptance, precharge-all is driven: CS low, RAS low, CAS high, WE low, address line 10 high and every other address line low.
- R4: Between precharge-all and mode-register-set there are exactly `cfg_trp` cycles, counting 0. In each of them both chip selects and RAS, CAS and WE are high.
- R5: Mode-register-set drives CS, RAS, CAS and WE low. The address lines carry X shifted right by 2 when `cfg_bus16`=0 and by 1 when `cfg_bus16`=1. Examples: 0x880 gives 0x220, 0x8C0 gives 0x230, 0x440 gives 0x220 and 0x420 gives 0x210.
- R6: `cpu_rdy` is low from the cycle after acceptance through the mode-register-set cycle, and high in the cycle after that. Stores presented while it is low are not accepted and start no sequence.
- R7: A store into either window with `cpu_size` not 0, while `cpu_rdy` is high, issues no command and leaves `cpu_rdy` high. It sets `err_size` in the next cycle, and `err_size` stays set until reset.
- R8: A window store while `cfg_valid` is 0 issues no command and leaves `err_size` unchanged.
- R9: Stores outside the two windows (for example 0xFFFFC840 or 0xFFFFF840) issue no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Bus configuration has been programmed |
| cfg_bus16 | input | 1 | 1: 16-bit external bus, 0: 32-bit |
| cfg_trp | input | TRP_W | Deselect cycles between precharge-all and mode-register-set |
| cpu_wr | input | 1 | CPU store strobe |
| cpu_addr | input | 32 | CPU store byte address |
| cpu_size | input | 2 | Store size: 0 byte, 1 halfword, 2 word |
| cpu_rdy | output | 1 | High when a store can be taken; low while a sequence runs |
| err_size | output | 1 | Sticky flag for a wrong-size window store |
| sd_cs2_n | output | 1 | Area 2 SDRAM chip select, active low |
| sd_cs3_n | output | 1 | Area 3 SDRAM chip select, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | SD_AW | SDRAM address lines in device numbering (SD_AW of at least 12) |

## Verification
The hardest case to reach from the ports is a store that arrives while the sequence is already in its deselect gap. It must be refused without disturbing the mode value already captured. The bench sets a gap of several cycles and raises a store to the other window in the middle of the gap. It then checks that the mode-register-set still carries the first value on the first chip select, and that no second precharge-all follows. A zero gap is driven separately, so that mode-register-set follows precharge-all directly. The bench also checks that a wrong-size store leaves the sticky flag set across a later good sequence, and that only reset clears it.

// File: rtl/sdram_mode_seq_pkg.sv
package sdram_mode_seq_pkg;

    localparam int OFS_W = 12;
    localparam logic [19:0] WIN_AREA2 = 20'hFFFFD;
    localparam logic [19:0] WIN_AREA3 = 20'hFFFFE;
    localparam logic [1:0]  SIZE_BYTE = 2'd0;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PALL,
        ST_WAIT,
        ST_MRS
    } seq_state_t;

    typedef enum logic {
        AREA_2 = 1'b0,
        AREA_3 = 1'b1
    } area_t;

    typedef struct packed {
        area_t             area;
        logic [OFS_W-1:0]  mode;
    } mode_req_t;

    typedef struct packed {
        logic cs2_n;
        logic cs3_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_DESEL = '{cs2_n: 1'b1, cs3_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic logic [OFS_W-1:0] offset_to_mode(input logic [OFS_W-1:0] ofs,
                                                        input logic bus16);
        return bus16 ? (ofs >> 1) : (ofs >> 2);
    endfunction

endpackage

// File: rtl/mrs_decode.sv
module mrs_decode
    import sdram_mode_seq_pkg::*;
(
    input  logic             cpu_wr,
    input  logic [31:0]      cpu_addr,
    input  logic [1:0]       cpu_size,
    input  logic             cfg_valid,
    input  logic             cfg_bus16,
    output logic             take,
    output logic             bad_size,
    output mode_req_t        req
);
    logic in_a2;
    logic in_a3;
    logic in_win;

    always_comb begin
        in_a2    = (cpu_addr[31:OFS_W] == WIN_AREA2);
        in_a3    = (cpu_addr[31:OFS_W] == WIN_AREA3);
        in_win   = cpu_wr && cfg_valid && (in_a2 || in_a3);
        take     = in_win && (cpu_size == SIZE_BYTE);
        bad_size = in_win && (cpu_size != SIZE_BYTE);
        req.area = in_a3 ? AREA_3 : AREA_2;
        req.mode = offset_to_mode(cpu_addr[OFS_W-1:0], cfg_bus16);
    end
endmodule

// File: rtl/mrs_fsm.sv
module mrs_fsm
    import sdram_mode_seq_pkg::*;
#(
    parameter int TRP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             bad_size,
    input  mode_req_t        req_in,
    input  logic [TRP_W-1:0] cfg_trp,
    output seq_state_t       state,
    output mode_req_t        req_q,
    output logic             cpu_rdy,
    output logic             err_size
);
    logic [TRP_W-1:0] gap_cnt;

    assign cpu_rdy = (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            req_q    <= '0;
            gap_cnt  <= '0;
            err_size <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take) begin
                        state <= ST_PALL;
                        req_q <= req_in;
                    end
                    if (bad_size) begin
                        err_size <= 1'b1;
                    end
                end
                ST_PALL: begin
                    if (cfg_trp == '0) begin
                        state <= ST_MRS;
                    end else begin
                        state   <= ST_WAIT;
                        gap_cnt <= cfg_trp - 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (gap_cnt == '0) begin
                        state <= ST_MRS;
                    end else begin
                        gap_cnt <= gap_cnt - 1'b1;
                    end
                end
                ST_MRS:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4
    mrs_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MRS) |-> ($past(state) == ST_PALL || $past(state) == ST_WAIT));

    // R6
    stall_after_pall_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PALL) |=> !cpu_rdy);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_size |=> err_size);
endmodule

// File: rtl/mrs_pins.sv
module mrs_pins
    import sdram_mode_seq_pkg::*;
#(
    parameter int SD_AW = 13
) (
    input  seq_state_t       state,
    input  mode_req_t        req_q,
    output sd_cmd_t          cmd,
    output logic [SD_AW-1:0] sd_addr
);
    localparam int A10 = 10;

    always_comb begin
        cmd     = CMD_DESEL;
        sd_addr = '0;
        unique case (state)
            ST_PALL: begin
                cmd.ras_n    = 1'b0;
                cmd.we_n     = 1'b0;
                sd_addr[A10] = 1'b1;
            end
            ST_MRS: begin
                cmd.ras_n    = 1'b0;
                cmd.cas_n    = 1'b0;
                cmd.we_n     = 1'b0;
                sd_addr[OFS_W-1:0] = req_q.mode;
            end
            default: ;
        endcase
        if (state == ST_PALL || state == ST_MRS) begin
            cmd.cs2_n = (req_q.area != AREA_2);
            cmd.cs3_n = (req_q.area != AREA_3);
        end
    end
endmodule

// File: rtl/sdram_mode_seq.sv
module sdram_mode_seq
    import sdram_mode_seq_pkg::*;
#(
    parameter int TRP_W = 4,
    parameter int SD_AW = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_valid,
    input  logic             cfg_bus16,
    input  logic [TRP_W-1:0] cfg_trp,
    input  logic             cpu_wr,
    input  logic [31:0]      cpu_addr,
    input  logic [1:0]       cpu_size,
    output logic             cpu_rdy,
    output logic             err_size,
    output logic             sd_cs2_n,
    output logic             sd_cs3_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [SD_AW-1:0] sd_addr
);
    logic       take;
    logic       bad_size;
    mode_req_t  req_in;
    mode_req_t  req_q;
    seq_state_t state;
    sd_cmd_t    cmd;

    mrs_decode u_decode (
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .cpu_size  (cpu_size),
        .cfg_valid (cfg_valid),
        .cfg_bus16 (cfg_bus16),
        .take      (take),
        .bad_size  (bad_size),
        .req       (req_in)
    );

    mrs_fsm #(.TRP_W(TRP_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .bad_size (bad_size),
        .req_in   (req_in),
        .cfg_trp  (cfg_trp),
        .state    (state),
        .req_q    (req_q),
        .cpu_rdy  (cpu_rdy),
        .err_size (err_size)
    );

    mrs_pins #(.SD_AW(SD_AW)) u_pins (
        .state   (state),
        .req_q   (req_q),
        .cmd     (cmd),
        .sd_addr (sd_addr)
    );

    assign sd_cs2_n = cmd.cs2_n;
    assign sd_cs3_n = cmd.cs3_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

    // R7
    bad_size_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (bad_size && cpu_rdy) |=> (sd_cs2_n && sd_cs3_n && cpu_rdy));

    // R6
    cmd_stalls_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        (!sd_cs2_n || !sd_cs3_n) |-> !cpu_rdy);

    // R2
    single_area_chk: assert property (@(posedge clk) disable iff (rst)
        !(!sd_cs2_n && !sd_cs3_n));
endmodule

// File: tb/tb_sdram_mode_seq.sv
module tb_sdram_mode_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TRP_W = 4;
    localparam int SD_AW = 13;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_valid;
    logic             cfg_bus16;
    logic [TRP_W-1:0] cfg_trp;
    logic             cpu_wr;
    logic [31:0]      cpu_addr;
    logic [1:0]       cpu_size;
    logic             cpu_rdy;
    logic             err_size;
    logic             sd_cs2_n, sd_cs3_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [SD_AW-1:0] sd_addr;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_mode_seq #(.TRP_W(TRP_W), .SD_AW(SD_AW)) dut (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_bus16(cfg_bus16),
        .cfg_trp(cfg_trp), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_rdy(cpu_rdy), .err_size(err_size), .sd_cs2_n(sd_cs2_n), .sd_cs3_n(sd_cs3_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr)
    );

    // pins vector: {cs2_n, cs3_n, ras_n, cas_n, we_n, rdy}
    function automatic logic [5:0] pins();
        return {sd_cs2_n, sd_cs3_n, sd_ras_n, sd_cas_n, sd_we_n, cpu_rdy};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cpu_wr = 1'b0;
        cpu_addr = '0;
        cpu_size = 2'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " idle pins"}, {26'd0, pins()}, {26'd0, 6'b111111});
        chk({tag, " idle addr"}, {19'd0, sd_addr}, 32'd0);
    endtask

    // full good sequence; poke raises a store to the other window mid-gap
    task automatic run_seq(input logic area3, input logic bus16, input logic [11:0] ofs,
                           input int trp, input logic poke);
        logic [12:0] exp_mode;
        logic [5:0]  act_cmd;
        exp_mode = bus16 ? {1'b0, ofs >> 1} : {1'b0, ofs >> 2};
        act_cmd  = area3 ? 6'b10_0000 : 6'b01_0000;
        cfg_bus16 = bus16;
        cfg_trp   = trp[TRP_W-1:0];
        cpu_wr    = 1'b1;
        cpu_size  = 2'd0;
        cpu_addr  = (area3 ? 32'hFFFFE000 : 32'hFFFFD000) | {20'd0, ofs};
        chk("R6 ready before accept", {31'd0, cpu_rdy}, 32'd1);
        @(negedge clk);
        cpu_wr = 1'b0;
        // R3 precharge-all, R2 only selected area
        chk("R3 R2 pall pins", {26'd0, pins()}, {26'd0, act_cmd | 6'b000100});
        chk("R3 pall addr", {19'd0, sd_addr}, 32'h400);
        for (int i = 0; i < trp; i++) begin
            if (poke && i == 0) begin
                cpu_wr   = 1'b1;
                cpu_addr = (area3 ? 32'hFFFFD000 : 32'hFFFFE000) | 32'h8C0;
            end
            @(negedge clk);
            chk("R4 gap deselect", {26'd0, pins()}, {26'd0, 6'b111110});
        end
        cpu_wr = 1'b0;
        @(negedge clk);
        // R5 mode-register-set
        chk("R5 R2 mrs pins", {26'd0, pins()}, {26'd0, act_cmd});
        chk("R5 mrs addr", {19'd0, sd_addr}, {19'd0, exp_mode});
        @(negedge clk);
        check_idle("R6 after mrs");
        if (poke) begin
            @(negedge clk);
            check_idle("R6 busy store refused");
        end
    endtask

    task automatic test_ignored(input string tag, input logic [31:0] addr,
                                input logic [1:0] size, input logic valid);
        cfg_valid = valid;
        cpu_wr    = 1'b1;
        cpu_addr  = addr;
        cpu_size  = size;
        @(negedge clk);
        cpu_wr    = 1'b0;
        check_idle(tag);
        @(negedge clk);
        check_idle(tag);
        cfg_valid = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cfg_valid = 1'b1;
        cfg_bus16 = 1'b0;
        cfg_trp   = '0;
        do_reset();
        // R1
        check_idle("R1 reset");
        chk("R1 reset err", {31'd0, err_size}, 32'd0);

        run_seq(1'b0, 1'b0, 12'h880, 2, 1'b0);   // area2 32-bit CL2
        run_seq(1'b1, 1'b1, 12'h460, 0, 1'b0);   // area3 16-bit CL3, zero gap
        run_seq(1'b0, 1'b1, 12'h420, 1, 1'b0);   // area2 16-bit CL1
        run_seq(1'b1, 1'b0, 12'h8C0, 3, 1'b1);   // area3 32-bit CL3, busy poke
        run_seq(1'b1, 1'b0, 12'h840, 0, 1'b0);   // area3 32-bit CL1

        // R8
        test_ignored("R8 cfg invalid", 32'hFFFFD880, 2'd0, 1'b0);
        chk("R8 no error", {31'd0, err_size}, 32'd0);
        // R9
        test_ignored("R9 below window", 32'hFFFFC840, 2'd0, 1'b1);
        test_ignored("R9 above window", 32'hFFFFF840, 2'd0, 1'b1);
        chk("R9 no error", {31'd0, err_size}, 32'd0);
        // R7
        test_ignored("R7 halfword", 32'hFFFFE880, 2'd1, 1'b1);
        chk("R7 err set", {31'd0, err_size}, 32'd1);
        test_ignored("R7 word", 32'hFFFFD880, 2'd2, 1'b1);
        run_seq(1'b0, 1'b0, 12'h880, 1, 1'b0);
        chk("R7 err sticky", {31'd0, err_size}, 32'd1);
        do_reset();
        chk("R1 err cleared by reset", {31'd0, err_size}, 32'd0);
        check_idle("R1 second reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule